// File: doc/BRIEF.md
# Uncached Load Entry Controller

This block controls a single slot of a queue that holds loads to uncached address space, either device (strongly ordered) loads or non-cacheable memory loads. A slot receives a load from the pipeline and holds its payload and age. When the load may go out, the slot raises a send request. It then follows the request through the issue holding register, the slot-id reply and the data reply from the downstream uncached buffer. Finally it offers a writeback to a load port and returns itself to the free list with a one-cycle pulse.

Pipeline redirects flush any slot that is younger than the redirect point. A slot whose request has not yet left is released in the same cycle as the redirect. A slot whose request is already outstanding keeps a deferred-flush mark until its own reply comes back. The reply then frees the slot without a writeback, so every request sent downstream is matched by exactly one reply that a slot absorbs.

Top module: `ucl_entry`

## Requirements
- R1: After reset the slot is empty: `send_req`, `wb_valid` and `free_pulse` are all 0.
- R2: `alloc_valid` loads the age, kind and payload into an empty slot. The slot ignores `alloc_valid` while it is occupied, and `wb_data` later shows the first payload.
- R3: A non-cacheable load (`alloc_mmio`=0) raises `send_req` in the second cycle after allocation, without waiting for `rob_is_head`.
- R4: A device load (`alloc_mmio`=1) keeps `send_req` low while `rob_is_head` is 0. It raises `send_req` one cycle after a cycle with `rob_is_head`=1.
- R5: `issue_fire` while `send_req` is high moves the slot to waiting for a reply, and `send_req` drops in the next cycle.
- R6: The first `idr_valid` after issue stores `idr_slot`. A data reply is taken only when `rsp_valid` is high and `rsp_slot` equals the stored slot id. Replies with any other slot id are ignored.
- R7: A matched reply raises `wb_valid` in the next cycle, and `wb_err` carries that reply's `rsp_err` (1 = corrupt or denied). `send_req` and `wb_valid` are never high together.
- R8: `wb_valid` stays high until `wb_ready` is sampled high. In that cycle `free_pulse` is 1, and the slot is empty in the next cycle.
- R9: A redirect hitting a slot with no request outstanding (idle, ready to send, or waiting to write back) gives `free_pulse`=1 in the redirect cycle and suppresses `wb_valid` in that cycle.
- R10: A redirect hitting a slot whose request is outstanding (including `issue_fire` in the same cycle) gives no release and no writeback. The matching reply later frees the slot with `free_pulse` and never raises `wb_valid`. A redirect in the same cycle as the matched reply frees the slot at once.
- R11: A redirect whose age equals or is younger than the slot's age has no effect. Ages are `AGE_W` bits: the top bit is a wrap flag and the rest is an index. A slot is younger when the flags are equal and its index is greater, or when the flags differ and its index is smaller.
- R12: `wb_port` is 2 for a device load. For a non-cacheable load it is `3 - NC_PORTS + ENTRY_IDX % NC_PORTS` (port 1 for slot 0 with two ports).
- R13: `free_pulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load into this slot |
| alloc_mmio | input | 1 | 1 = device load, 0 = non-cacheable load |
| alloc_age | input | AGE_W | Age of the load (wrap flag + index) |
| alloc_data | input | PAY_W | Load payload |
| redir_valid | input | 1 | Pipeline redirect |
| redir_age | input | AGE_W | Age of the redirect point |
| rob_is_head | input | 1 | This slot's load is the oldest in the reorder buffer |
| issue_fire | input | 1 | Issue holding register captured this slot's request |
| idr_valid | input | 1 | Slot-id reply for this slot |
| idr_slot | input | SLOT_W | Downstream slot id |
| rsp_valid | input | 1 | Data reply from the uncached buffer |
| rsp_slot | input | SLOT_W | Downstream slot id of the reply |
| rsp_err | input | 1 | Reply was corrupt or denied |
| wb_ready | input | 1 | Load port accepts the writeback |
| send_req | output | 1 | Slot requests bus access |
| wb_valid | output | 1 | Writeback offered |
| wb_port | output | 2 | Load port number for the writeback |
| wb_data | output | PAY_W | Payload written back |
| wb_err | output | 1 | Exception flag for the writeback |
| free_pulse | output | 1 | One-cycle release to the free list |

## Verification
The hardest situations to reach are those where a redirect lands on a request in flight. One case is a redirect in the very cycle the issue register captures the request. Another is a redirect in the same cycle as the matched reply. A third is a deferred slot that receives a reply tagged with a different slot id. The stimulus reaches each of them by stepping one slot through its life one cycle at a time and placing `redir_valid`, `issue_fire` and `rsp_valid` in chosen cycles. Some of the ages used straddle the wrap flag. A behavioural model in the bench tracks the slot alongside and is compared on every cycle.

// File: rtl/ucl_pkg.sv
package ucl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2,
    ST_WAIT = 2'd3
  } life_t;

  // Load port used for writeback: device loads use port 2, non-cacheable
  // loads are spread over the highest nports ports by slot index.
  function automatic logic [1:0] wb_port_of(input logic mmio, input int idx, input int nports);
    int p;
    p = mmio ? 2 : (3 - nports + (idx % nports));
    return p[1:0];
  endfunction

endpackage

// File: rtl/ucl_age_cmp.sv
module ucl_age_cmp #(
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_valid,
  input  logic [AGE_W-1:0] entry_age,
  input  logic             redir_valid,
  input  logic [AGE_W-1:0] redir_age,
  output logic             flush
);
  localparam int IDX_W = AGE_W - 1;

  function automatic logic is_younger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    if (a[AGE_W-1] == b[AGE_W-1]) return a[IDX_W-1:0] > b[IDX_W-1:0];
    else                          return a[IDX_W-1:0] < b[IDX_W-1:0];
  endfunction

  assign flush = entry_valid && redir_valid && is_younger(entry_age, redir_age);

  p_equal_age_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_age == entry_age) |-> !flush);

endmodule

// File: rtl/ucl_slot_track.sv
module ucl_slot_track #(
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_resp,
  input  logic              idr_valid,
  input  logic [SLOT_W-1:0] idr_slot,
  input  logic              rsp_valid,
  input  logic [SLOT_W-1:0] rsp_slot,
  input  logic              flush_defer,
  output logic              accepted,
  output logic [SLOT_W-1:0] slot,
  output logic              defer_q,
  output logic              rsp_hit
);
  logic              acc_q;
  logic [SLOT_W-1:0] slot_q;
  logic              def_q;

  assign rsp_hit  = in_resp && acc_q && rsp_valid && (rsp_slot == slot_q);
  assign accepted = acc_q;
  assign slot     = slot_q;
  assign defer_q  = def_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      slot_q <= '0;
      def_q  <= 1'b0;
    end else if (clear) begin
      acc_q <= 1'b0;
      def_q <= 1'b0;
    end else begin
      if (in_resp && idr_valid && !acc_q) begin
        acc_q  <= 1'b1;
        slot_q <= idr_slot;
      end
      if (rsp_hit)          def_q <= 1'b0;
      else if (flush_defer) def_q <= 1'b1;
    end
  end

  p_slot_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !clear) |=> $stable(slot_q));

  p_defer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (def_q && !rsp_hit && !clear) |=> def_q);

endmodule

// File: rtl/ucl_life_fsm.sv
module ucl_life_fsm
  import ucl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  can_send,
  input  logic  issue_fire,
  input  logic  rsp_hit,
  input  logic  defer_q,
  input  logic  flush,
  input  logic  wb_ready,
  output life_t state,
  output logic  send_req,
  output logic  wb_valid,
  output logic  wb_fire,
  output logic  flush_defer,
  output logic  free_pulse,
  output logic  in_resp
);
  life_t state_q, state_d;
  logic  outstanding, free_now, free_late;

  assign state       = state_q;
  assign in_resp     = (state_q == ST_RESP);
  assign send_req    = (state_q == ST_REQ);
  assign outstanding = in_resp || (send_req && issue_fire);
  assign free_now    = flush && (!outstanding || rsp_hit);
  assign free_late   = rsp_hit && defer_q;
  assign flush_defer = flush && outstanding && !rsp_hit;
  assign wb_valid    = (state_q == ST_WAIT) && !flush;
  assign wb_fire     = wb_valid && wb_ready;
  assign free_pulse  = wb_fire || free_now || free_late;

  always_comb begin
    state_d = state_q;
    if (free_pulse) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (can_send)   state_d = ST_REQ;
        ST_REQ:  if (issue_fire) state_d = ST_RESP;
        ST_RESP: if (rsp_hit)    state_d = ST_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  p_release_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    free_pulse |=> !free_pulse);

  p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_pulse |=> (state_q == ST_IDLE) && !wb_valid);

  p_issue_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && issue_fire) |=> !send_req);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_req, wb_valid}));

endmodule

// File: rtl/ucl_entry.sv
module ucl_entry
  import ucl_pkg::*;
#(
  parameter int AGE_W     = 6,
  parameter int SLOT_W    = 3,
  parameter int PAY_W     = 16,
  parameter int ENTRY_IDX = 0,
  parameter int NC_PORTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_mmio,
  input  logic [AGE_W-1:0]  alloc_age,
  input  logic [PAY_W-1:0]  alloc_data,
  input  logic              redir_valid,
  input  logic [AGE_W-1:0]  redir_age,
  input  logic              rob_is_head,
  input  logic              issue_fire,
  input  logic              idr_valid,
  input  logic [SLOT_W-1:0] idr_slot,
  input  logic              rsp_valid,
  input  logic [SLOT_W-1:0] rsp_slot,
  input  logic              rsp_err,
  input  logic              wb_ready,
  output logic              send_req,
  output logic              wb_valid,
  output logic [1:0]        wb_port,
  output logic [PAY_W-1:0]  wb_data,
  output logic              wb_err,
  output logic              free_pulse
);
  logic              valid_q, mmio_q, err_q;
  logic [AGE_W-1:0]  age_q;
  logic [PAY_W-1:0]  data_q;

  // named internal events
  logic              ev_alloc, ev_flush, ev_can_send, ev_rsp_hit;
  logic              ev_flush_defer, ev_wb_fire, ev_in_resp;
  logic              trk_defer, trk_accepted;
  logic [SLOT_W-1:0] trk_slot;
  life_t             state;

  assign ev_alloc    = alloc_valid && !valid_q;
  assign ev_can_send = valid_q && (!mmio_q || rob_is_head);

  ucl_age_cmp #(.AGE_W(AGE_W)) u_age (
    .clk(clk), .rst_n(rst_n),
    .entry_valid(valid_q), .entry_age(age_q),
    .redir_valid(redir_valid), .redir_age(redir_age),
    .flush(ev_flush)
  );

  ucl_life_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .can_send(ev_can_send), .issue_fire(issue_fire), .rsp_hit(ev_rsp_hit),
    .defer_q(trk_defer), .flush(ev_flush), .wb_ready(wb_ready),
    .state(state), .send_req(send_req), .wb_valid(wb_valid), .wb_fire(ev_wb_fire),
    .flush_defer(ev_flush_defer), .free_pulse(free_pulse), .in_resp(ev_in_resp)
  );

  ucl_slot_track #(.SLOT_W(SLOT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clear(ev_alloc), .in_resp(ev_in_resp),
    .idr_valid(idr_valid), .idr_slot(idr_slot),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .flush_defer(ev_flush_defer),
    .accepted(trk_accepted), .slot(trk_slot), .defer_q(trk_defer), .rsp_hit(ev_rsp_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mmio_q  <= 1'b0;
      age_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ev_alloc) begin
        valid_q <= 1'b1;
        mmio_q  <= alloc_mmio;
        age_q   <= alloc_age;
        data_q  <= alloc_data;
        err_q   <= 1'b0;
      end else if (free_pulse) begin
        valid_q <= 1'b0;
      end
      if (ev_rsp_hit) err_q <= rsp_err;
    end
  end

  assign wb_port = wb_port_of(mmio_q, ENTRY_IDX, NC_PORTS);
  assign wb_data = data_q;
  assign wb_err  = err_q;

  p_mmio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mmio_q && !rob_is_head && state == ST_IDLE) |=> !send_req);

  p_free_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_pulse |=> !valid_q);

  p_accept_needs_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trk_accepted) |-> $past(ev_in_resp));

  p_wb_only_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> valid_q && !trk_defer);

  p_fire_gives_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_fire |-> free_pulse);

endmodule

// File: tb/test_ucl_entry.sv
module test_ucl_entry;
  localparam int AGE_W = 6, SLOT_W = 3, PAY_W = 16, IDX = 0, NCP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid, alloc_mmio, redir_valid, rob_is_head, issue_fire;
  logic idr_valid, rsp_valid, rsp_err, wb_ready;
  logic [AGE_W-1:0] alloc_age, redir_age;
  logic [PAY_W-1:0] alloc_data;
  logic [SLOT_W-1:0] idr_slot, rsp_slot;
  logic send_req, wb_valid, wb_err, free_pulse;
  logic [1:0] wb_port;
  logic [PAY_W-1:0] wb_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ucl_entry #(.AGE_W(AGE_W), .SLOT_W(SLOT_W), .PAY_W(PAY_W), .ENTRY_IDX(IDX), .NC_PORTS(NCP)) i_ucl_entry (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_mmio(alloc_mmio),
    .alloc_age(alloc_age), .alloc_data(alloc_data), .redir_valid(redir_valid),
    .redir_age(redir_age), .rob_is_head(rob_is_head), .issue_fire(issue_fire),
    .idr_valid(idr_valid), .idr_slot(idr_slot), .rsp_valid(rsp_valid), .rsp_slot(rsp_slot),
    .rsp_err(rsp_err), .wb_ready(wb_ready), .send_req(send_req), .wb_valid(wb_valid),
    .wb_port(wb_port), .wb_data(wb_data), .wb_err(wb_err), .free_pulse(free_pulse)
  );

  // behavioural model: slot life as integers
  int m_valid = 0, m_st = 0, m_mmio = 0, m_age = 0, m_pay = 0;
  int m_acc = 0, m_slot = 0, m_def = 0, m_err = 0;
  int e_send, e_wbv, e_rel, e_port;
  int n_valid, n_st, n_mmio, n_age, n_pay, n_acc, n_slot, n_def, n_err;

  // circular distance form of the age order
  function automatic int younger(int a, int b);
    int d;
    d = (a - b) & ((1 << AGE_W) - 1);
    return (d > 0 && d < (1 << (AGE_W - 1))) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    int fl, hit, infl;
    fl   = (m_valid != 0 && redir_valid && younger(m_age, int'(redir_age)) != 0) ? 1 : 0;
    hit  = (m_valid != 0 && m_st == 2 && m_acc != 0 && rsp_valid && int'(rsp_slot) == m_slot) ? 1 : 0;
    infl = (m_valid != 0 && (m_st == 2 || (m_st == 1 && issue_fire))) ? 1 : 0;
    e_send = (m_valid != 0 && m_st == 1) ? 1 : 0;
    e_wbv  = (m_valid != 0 && m_st == 3 && fl == 0) ? 1 : 0;
    e_rel  = ((e_wbv != 0 && wb_ready) || (fl != 0 && (infl == 0 || hit != 0)) || (hit != 0 && m_def != 0)) ? 1 : 0;
    e_port = (m_mmio != 0) ? 2 : (3 - NCP + IDX % NCP);
    n_valid = m_valid; n_st = m_st; n_mmio = m_mmio; n_age = m_age; n_pay = m_pay;
    n_acc = m_acc; n_slot = m_slot; n_def = m_def; n_err = m_err;
    if (e_rel != 0) begin
      n_valid = 0; n_st = 0; n_def = 0;
    end else if (m_valid == 0) begin
      if (alloc_valid) begin
        n_valid = 1; n_st = 0; n_mmio = int'(alloc_mmio); n_age = int'(alloc_age);
        n_pay = int'(alloc_data); n_acc = 0; n_def = 0; n_err = 0;
      end
    end else begin
      case (m_st)
        0: if (m_mmio == 0 || rob_is_head) n_st = 1;
        1: if (issue_fire) begin n_st = 2; if (fl != 0) n_def = 1; end
        2: begin
          if (idr_valid && m_acc == 0) begin n_acc = 1; n_slot = int'(idr_slot); end
          if (hit != 0) begin n_st = 3; n_err = int'(rsp_err); end
          else if (fl != 0) n_def = 1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic clear_inputs();
    alloc_valid = 0; alloc_mmio = 0; alloc_age = '0; alloc_data = '0;
    redir_valid = 0; redir_age = '0; rob_is_head = 0; issue_fire = 0;
    idr_valid = 0; idr_slot = '0; rsp_valid = 0; rsp_slot = '0; rsp_err = 0; wb_ready = 0;
  endtask

  // inputs are set at the falling edge; compare after settling, then advance
  task automatic tick();
    #2;
    model_eval();
    check(int'(send_req) == e_send, "R3 send_req", int'(send_req), e_send);
    check(int'(wb_valid) == e_wbv, "R7 wb_valid", int'(wb_valid), e_wbv);
    check(int'(free_pulse) == e_rel, "R8 free_pulse", int'(free_pulse), e_rel);
    if (e_wbv != 0) begin
      check(int'(wb_port) == e_port, "R12 wb_port", int'(wb_port), e_port);
      check(int'(wb_data) == m_pay, "R2 wb_data", int'(wb_data), m_pay);
      check(int'(wb_err) == m_err, "R7 wb_err", int'(wb_err), m_err);
    end
    @(posedge clk);
    m_valid = n_valid; m_st = n_st; m_mmio = n_mmio; m_age = n_age; m_pay = n_pay;
    m_acc = n_acc; m_slot = n_slot; m_def = n_def; m_err = n_err;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic do_alloc(input int mmio, input int age, input int pay);
    alloc_valid = 1; alloc_mmio = mmio[0]; alloc_age = age[AGE_W-1:0]; alloc_data = pay[PAY_W-1:0];
    tick();
  endtask

  task automatic settle(); #1; endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!send_req && !wb_valid && !free_pulse, "R1 reset outputs", int'({send_req, wb_valid, free_pulse}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!send_req && !wb_valid && !free_pulse, "R1 idle after reset", int'({send_req, wb_valid, free_pulse}), 0);

    // NC life, second allocation ignored (R2), wrong slot ignored (R6)
    do_alloc(0, 5, 16'hA1A1);
    do_alloc(0, 9, 16'hBEEF);
    check(send_req, "R3 send after two cycles", int'(send_req), 1);
    issue_fire = 1; tick();
    check(!send_req, "R5 send drops after issue", int'(send_req), 0);
    idr_valid = 1; idr_slot = 3; tick();
    rsp_valid = 1; rsp_slot = 2; tick();
    check(!wb_valid, "R6 foreign slot reply ignored", int'(wb_valid), 0);
    rsp_valid = 1; rsp_slot = 3; rsp_err = 0; tick();
    check(wb_valid && wb_data == 16'hA1A1, "R2 first payload kept", int'(wb_data), 16'hA1A1);
    tick();
    wb_ready = 1; settle();
    check(free_pulse, "R8 release on accept", int'(free_pulse), 1);
    tick();
    check(!free_pulse && !wb_valid, "R13 single pulse", int'(free_pulse), 0);

    // device load waits for head, error reply
    do_alloc(1, 10, 16'h0C0D);
    for (int i = 0; i < 3; i++) begin
      tick();
      check(!send_req, "R4 device load waits for head", int'(send_req), 0);
    end
    rob_is_head = 1; tick();
    check(send_req, "R4 send after head", int'(send_req), 1);
    issue_fire = 1; tick();
    idr_valid = 1; idr_slot = 1; tick();
    rsp_valid = 1; rsp_slot = 1; rsp_err = 1; tick();
    check(wb_err && wb_port == 2'd2, "R7 R12 device error writeback", int'({wb_err, wb_port}), 6);
    wb_ready = 1; tick();

    // flush while idle (R9)
    do_alloc(1, 20, 16'h1111);
    redir_valid = 1; redir_age = 19; settle();
    check(free_pulse, "R9 flush idle frees at once", int'(free_pulse), 1);
    tick(); tick();

    // equal and younger redirect (R11), then flush with issue (R10)
    do_alloc(0, 20, 16'h2222);
    redir_valid = 1; redir_age = 20; tick();
    redir_valid = 1; redir_age = 25; tick();
    check(send_req, "R11 no flush from equal or younger redirect", int'(send_req), 1);
    issue_fire = 1; redir_valid = 1; redir_age = 15; settle();
    check(!free_pulse, "R10 flush with issue deferred", int'(free_pulse), 0);
    tick();
    idr_valid = 1; idr_slot = 4; tick();
    tick(); tick();
    rsp_valid = 1; rsp_slot = 6; tick();
    rsp_valid = 1; rsp_slot = 4; settle();
    check(free_pulse && !wb_valid, "R10 deferred flush freed by reply", int'(free_pulse), 1);
    tick();
    check(!wb_valid, "R10 no writeback after deferred flush", int'(wb_valid), 0);
    tick();

    // flush in reply wait with wrapped ages
    do_alloc(0, 40, 16'h4040);
    tick();
    issue_fire = 1; tick();
    idr_valid = 1; idr_slot = 2; redir_valid = 1; redir_age = 35; tick();
    redir_valid = 1; redir_age = 60; tick();
    rsp_valid = 1; rsp_slot = 2; tick();
    tick();

    // flush in the same cycle as the reply, across the wrap
    do_alloc(0, 2, 16'h0202);
    tick();
    issue_fire = 1; tick();
    idr_valid = 1; idr_slot = 5; tick();
    rsp_valid = 1; rsp_slot = 5; redir_valid = 1; redir_age = 62; settle();
    check(free_pulse, "R10 flush with reply frees now", int'(free_pulse), 1);
    tick();
    check(!wb_valid, "R9 no writeback after flush", int'(wb_valid), 0);

    // flush while waiting to write back, with wb_ready
    do_alloc(0, 7, 16'h0707);
    tick();
    issue_fire = 1; tick();
    idr_valid = 1; idr_slot = 0; tick();
    rsp_valid = 1; rsp_slot = 0; tick();
    redir_valid = 1; redir_age = 6; wb_ready = 1; settle();
    check(!wb_valid && free_pulse, "R9 flush suppresses writeback", int'(wb_valid), 0);
    tick();
    tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule